// File: doc/BRIEF.md
# Clock Source Switchover Controller

This controller decides which oscillator feeds the system clock of a low-power microcontroller and how fast the CPU runs from it. Each time the device comes out of sleep (and after reset) it starts on the fast RC oscillator. It then moves to the crystal-derived clock according to one of three software policies. Under the automatic policy it moves as soon as the crystal reports ready. Under the manual policy it waits for a software switch command. Under the hold policy it stays on RC until the next sleep. The oscillators themselves are outside the block. The controller drives one select enable per source, and every change passes through a break-before-make gap in which neither enable is high.

The CPU clock is produced as a tick strobe on the system clock. It is set by a frequency code that picks one of six rates: the full rate or a division by a power of two, down to 1/32. The low-frequency sleep clock has a separate one-hot select. It starts on the internal RC source and can be moved once to the crystal or to the external input. After that the choice stays fixed until reset. A status word reports the active system source, a pending switch request and the sleep-clock choice.

Top module: `clksw_top`

## Requirements
- R1: After reset, and after every wake event, both system select enables stay low until `rcReady` is sampled high. The RC enable then rises, and it is the only source a wake can start on.
- R2: With `policy` = 0 (automatic), once the RC enable is high and `xtalReady` is sampled high, the controller moves to the crystal enable without any software action.
- R3: With `policy` = 1 (manual), the controller stays on RC until a `swSwitch` pulse. A pulse that arrives while `xtalReady` is low is held pending, shown in `status[1]`, and carried out when `xtalReady` rises. The pending flag clears when the switch begins.
- R4: With `policy` = 2 or 3 (hold), the controller stays on RC whatever `xtalReady` and `swSwitch` do, until it sleeps.
- R5: The two system enables are never high together. The crystal enable rises only after the RC enable has been low for at least GAP_CYCLES clock cycles.
- R6: A `sleepReq` sampled while running on RC, in the gap, or on the crystal drops both system enables, raises `asleep` and clears any pending switch. `wakeEvt` ends the sleep.
- R7: The CPU frequency code k (0..5) makes `cpuTick` pulse once every 2^(5-k) clock cycles while a system enable is high. Code 5 is full rate and is the reset setting. There are no ticks while both system enables are low.
- R8: Frequency codes 6 and 7 are ignored, and the previous setting stays in force.
- R9: After reset the sleep clock is the internal RC (`slpRcEn` high). A write of code 1 (crystal) or 2 (external) is accepted once. On acceptance all sleep enables go low for one cycle, then the new one rises.
- R10: Once a non-RC sleep source has been accepted, further writes are ignored until reset. Writes of code 0 or 3 never change the sleep source.
- R11: `status` bit 0 is the crystal system enable, bit 1 is the pending-switch flag, bits 3:2 are the sleep source code (0 RC, 1 crystal, 2 external), and bit 4 shows that the sleep source is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rcReady | input | 1 | Fast RC oscillator is running |
| xtalReady | input | 1 | Crystal oscillator has started |
| wakeEvt | input | 1 | Wake event ending sleep |
| sleepReq | input | 1 | Request to enter sleep |
| swSwitch | input | 1 | Software command to move to the crystal (manual policy) |
| policy | input | 2 | 0 automatic, 1 manual, 2/3 hold |
| divCode | input | 3 | CPU frequency code, 0 slowest to 5 full rate |
| slpSrcWr | input | 1 | Write strobe for the sleep-clock source |
| slpSrcSel | input | 2 | Requested sleep source: 1 crystal, 2 external |
| rcSelEn | output | 1 | Glitch-free select for the RC system source |
| xtalSelEn | output | 1 | Glitch-free select for the crystal system source |
| cpuTick | output | 1 | CPU clock enable strobe |
| asleep | output | 1 | Controller is in the sleep state |
| slpRcEn | output | 1 | Sleep clock from internal RC |
| slpXtalEn | output | 1 | Sleep clock from crystal |
| slpExtEn | output | 1 | Sleep clock from external input |
| status | output | 5 | Status word (see R11) |

## Verification
The embedded assertions check these rules on every cycle:
- the two system selects are never high together, and the crystal select only rises out of a low RC select;
- the hold policy keeps the controller on RC;
- a sleep request always reaches the sleep state;
- the sleep-clock source is stable once locked, and its enables are one-hot or all low;
- two back-to-back CPU ticks occur only at full rate.

Other behaviour only shows up in the bench's scenarios:
- a manual switch that waits pending for the crystal;
- the exact length of the break gap;
- tick counts per rate over a whole window;
- ignored frequency codes;
- rejected sleep-source writes before and after locking.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_WAITRC = 3'd0,
    ST_RUNRC  = 3'd1,
    ST_GAP    = 3'd2,
    ST_RUNXT  = 3'd3,
    ST_SLEEP  = 3'd4
  } sysState_e;

  typedef struct packed {
    logic wantRc;
    logic wantXtal;
    logic gapLoad;
  } ctrlStrobe_t;

  localparam logic [1:0] POL_AUTO   = 2'd0;
  localparam logic [1:0] POL_MANUAL = 2'd1;

  localparam logic [1:0] SLP_RC   = 2'd0;
  localparam logic [1:0] SLP_XTAL = 2'd1;
  localparam logic [1:0] SLP_EXT  = 2'd2;

endpackage

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rcReady,
  input  logic        xtalReady,
  input  logic        wakeEvt,
  input  logic        sleepReq,
  input  logic        swSwitch,
  input  logic [1:0]  policy,
  input  logic        gapDone,
  output ctrlStrobe_t strobe,
  output logic        asleep,
  output logic        pending
);

  sysState_e state, stateNext;
  logic      pendNext;
  logic      autoGo, manGo, go;

  always_comb begin
    stateNext = state;
    pendNext  = 1'b0;
    autoGo    = 1'b0;
    manGo     = 1'b0;
    go        = 1'b0;
    case (state)
      ST_WAITRC: if (rcReady) stateNext = ST_RUNRC;
      ST_RUNRC: begin
        if (sleepReq) begin
          stateNext = ST_SLEEP;
        end else begin
          autoGo = (policy == POL_AUTO) && xtalReady;
          manGo  = (policy == POL_MANUAL) && (pending || swSwitch) && xtalReady;
          go     = autoGo || manGo;
          if (go) stateNext = ST_GAP;
          else    pendNext  = pending || ((policy == POL_MANUAL) && swSwitch);
        end
      end
      ST_GAP: begin
        if (sleepReq)     stateNext = ST_SLEEP;
        else if (gapDone) stateNext = ST_RUNXT;
      end
      ST_RUNXT: if (sleepReq) stateNext = ST_SLEEP;
      ST_SLEEP: if (wakeEvt)  stateNext = ST_WAITRC;
      default:  stateNext = ST_WAITRC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAITRC;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendNext;
    end
  end

  always_comb begin
    strobe.wantRc   = (state == ST_RUNRC);
    strobe.wantXtal = (state == ST_RUNXT);
    strobe.gapLoad  = go;
  end

  assign asleep = (state == ST_SLEEP);

  // R4: hold policy keeps the RC source while no sleep is requested
  a_r4_hold_stays: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUNRC && policy[1] && !sleepReq) |=> (state == ST_RUNRC));

  // R6: a sleep request from any running state reaches sleep
  a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUNRC || state == ST_GAP || state == ST_RUNXT) && sleepReq)
      |=> (asleep && !pending));

endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int GAP_CYCLES = 2,
  parameter int DIV_BITS   = 5,
  localparam int CODE_W    = $clog2(DIV_BITS + 1),
  localparam int GAP_W     = $clog2(GAP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CODE_W-1:0] divCode,
  output logic              rcSelEn,
  output logic              xtalSelEn,
  output logic              gapDone,
  output logic              cpuTick
);

  localparam logic [GAP_W-1:0]  GAP_LOAD = GAP_W'(GAP_CYCLES - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(DIV_BITS);

  logic [GAP_W-1:0]    gapCnt;
  logic [CODE_W-1:0]   divSel;
  logic [DIV_BITS-1:0] divCnt;
  logic [DIV_BITS-1:0] divMask;
  logic                sysOn;

  // select enables: registered so each is a clean level from one flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcSelEn   <= 1'b0;
      xtalSelEn <= 1'b0;
    end else begin
      rcSelEn   <= strobe.wantRc;
      xtalSelEn <= strobe.wantXtal;
    end
  end

  // break-before-make gap timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (strobe.gapLoad)  gapCnt <= GAP_LOAD;
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end
  assign gapDone = (gapCnt == '0);

  // CPU frequency selection and tick generation
  assign sysOn   = rcSelEn || xtalSelEn;
  assign divMask = {DIV_BITS{1'b1}} >> divSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSel  <= CODE_MAX;
      divCnt  <= '0;
      cpuTick <= 1'b0;
    end else begin
      if (divCode <= CODE_MAX) divSel <= divCode;
      divCnt  <= sysOn ? divCnt + 1'b1 : '0;
      cpuTick <= sysOn && ((divCnt & divMask) == '0);
    end
  end

  // R5: the two system selects are never active together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rcSelEn && xtalSelEn));

  // R5: crystal select only rises out of a released RC select
  a_r5_break_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xtalSelEn) |-> $past(!rcSelEn));

  // R7: back-to-back ticks only at the full-rate setting
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTick && $past(cpuTick) && ($past(divSel) == $past(divSel, 2)))
      |-> ($past(divSel) == CODE_MAX));

endmodule

// File: rtl/clksw_slpsel.sv
module clksw_slpsel
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slpSrcWr,
  input  logic [1:0] slpSrcSel,
  output logic [2:0] slpEn,
  output logic [1:0] slpSrc,
  output logic       locked
);

  logic accept;
  logic [2:0] srcOneHot;

  assign locked    = (slpSrc != SLP_RC);
  assign accept    = slpSrcWr && !locked &&
                     (slpSrcSel == SLP_XTAL || slpSrcSel == SLP_EXT);
  assign srcOneHot = 3'b001 << slpSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slpSrc <= SLP_RC;
      slpEn  <= 3'b001;
    end else begin
      if (accept) slpSrc <= slpSrcSel;
      slpEn <= accept ? 3'b000 : srcOneHot;
    end
  end

  // R10: a locked sleep source never moves
  a_r10_locked_stable: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(slpSrc));

  // R9: at most one sleep source enabled at a time
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slpEn));

endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int GAP_CYCLES = 2,
  parameter int DIV_BITS   = 5,
  localparam int CODE_W    = $clog2(DIV_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rcReady,
  input  logic              xtalReady,
  input  logic              wakeEvt,
  input  logic              sleepReq,
  input  logic              swSwitch,
  input  logic [1:0]        policy,
  input  logic [CODE_W-1:0] divCode,
  input  logic              slpSrcWr,
  input  logic [1:0]        slpSrcSel,
  output logic              rcSelEn,
  output logic              xtalSelEn,
  output logic              cpuTick,
  output logic              asleep,
  output logic              slpRcEn,
  output logic              slpXtalEn,
  output logic              slpExtEn,
  output logic [4:0]        status
);

  ctrlStrobe_t strobe;
  logic        gapDone;
  logic        pending;
  logic [2:0]  slpEn;
  logic [1:0]  slpSrc;
  logic        locked;

  clksw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rcReady(rcReady), .xtalReady(xtalReady),
    .wakeEvt(wakeEvt), .sleepReq(sleepReq), .swSwitch(swSwitch),
    .policy(policy), .gapDone(gapDone), .strobe(strobe),
    .asleep(asleep), .pending(pending)
  );

  clksw_datapath #(.GAP_CYCLES(GAP_CYCLES), .DIV_BITS(DIV_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divCode(divCode),
    .rcSelEn(rcSelEn), .xtalSelEn(xtalSelEn), .gapDone(gapDone),
    .cpuTick(cpuTick)
  );

  clksw_slpsel u_slp (
    .clk(clk), .rstN(rstN), .slpSrcWr(slpSrcWr), .slpSrcSel(slpSrcSel),
    .slpEn(slpEn), .slpSrc(slpSrc), .locked(locked)
  );

  assign slpRcEn   = slpEn[0];
  assign slpXtalEn = slpEn[1];
  assign slpExtEn  = slpEn[2];
  assign status    = {locked, slpSrc, pending, xtalSelEn};

endmodule

// File: tb/clksw_top_bench.sv
`timescale 1ns/1ps
module clksw_top_bench;

  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rcReady = 0, xtalReady = 0, wakeEvt = 0, sleepReq = 0, swSwitch = 0;
  logic [1:0] policy = 2'd0;
  logic [2:0] divCode = 3'd5;
  logic slpSrcWr = 0;
  logic [1:0] slpSrcSel = 2'd0;
  logic rcSelEn, xtalSelEn, cpuTick, asleep, slpRcEn, slpXtalEn, slpExtEn;
  logic [4:0] status;

  int nChecks = 0;
  int nErrors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  clksw_top #(.GAP_CYCLES(GAP)) u_clksw_top (
    .clk(clk), .rstN(rstN), .rcReady(rcReady), .xtalReady(xtalReady),
    .wakeEvt(wakeEvt), .sleepReq(sleepReq), .swSwitch(swSwitch),
    .policy(policy), .divCode(divCode), .slpSrcWr(slpSrcWr),
    .slpSrcSel(slpSrcSel), .rcSelEn(rcSelEn), .xtalSelEn(xtalSelEn),
    .cpuTick(cpuTick), .asleep(asleep), .slpRcEn(slpRcEn),
    .slpXtalEn(slpXtalEn), .slpExtEn(slpExtEn), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 waiting for RC, 1 on RC, 2 gap, 3 on crystal, 4 sleep
  int mSt, mPend, mGap, mRc, mXt, mDiv, mCnt, mTick, mSlp, mSlpEn;
  int nSt, nPend, nGap, nDiv, nCnt, nTick, nSlp, nSlpEn, sysOn, period, acc;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mPend = 0; mGap = 0; mRc = 0; mXt = 0;
      mDiv = 5; mCnt = 0; mTick = 0; mSlp = 0; mSlpEn = 1;
    end else begin
      sysOn  = (mRc != 0 || mXt != 0) ? 1 : 0;
      period = 1 << (5 - mDiv);
      nTick  = (sysOn != 0 && (mCnt % period) == 0) ? 1 : 0;
      nCnt   = sysOn != 0 ? (mCnt + 1) % 32 : 0;
      nDiv   = (divCode <= 3'd5) ? int'(divCode) : mDiv;
      nSt = mSt; nPend = 0; nGap = (mGap > 0) ? mGap - 1 : 0;
      case (mSt)
        0: if (rcReady) nSt = 1;
        1: if (sleepReq) nSt = 4;
           else if ((policy == 2'd0 && xtalReady) ||
                    (policy == 2'd1 && xtalReady && (mPend != 0 || swSwitch))) begin
             nSt = 2; nGap = GAP - 1;
           end else nPend = (mPend != 0 || (policy == 2'd1 && swSwitch)) ? 1 : 0;
        2: if (sleepReq) nSt = 4; else if (mGap == 0) nSt = 3;
        3: if (sleepReq) nSt = 4;
        default: if (wakeEvt) nSt = 0;
      endcase
      acc    = (slpSrcWr && mSlp == 0 && (slpSrcSel == 2'd1 || slpSrcSel == 2'd2)) ? 1 : 0;
      nSlpEn = acc != 0 ? 0 : (1 << mSlp);
      nSlp   = acc != 0 ? int'(slpSrcSel) : mSlp;
      mRc = (mSt == 1) ? 1 : 0;
      mXt = (mSt == 3) ? 1 : 0;
      mSt = nSt; mPend = nPend; mGap = nGap; mDiv = nDiv; mCnt = nCnt;
      mTick = nTick; mSlp = nSlp; mSlpEn = nSlpEn;
    end
  end

  // per-cycle comparison, away from the active edge
  int lowRun = 0;
  logic prevXt = 0;
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk("R1/R2 rcSelEn", rcSelEn, mRc);
      chk("R2/R3 xtalSelEn", xtalSelEn, mXt);
      chk("R7 cpuTick", cpuTick, mTick);
      chk("R6 asleep", asleep, mSt == 4 ? 1 : 0);
      chk("R9 sleep enables", {slpExtEn, slpXtalEn, slpRcEn}, mSlpEn);
      chk("R11 status", status,
          ((mSlp != 0 ? 1 : 0) << 4) | (mSlp << 2) | (mPend << 1) | mXt);
      if (xtalSelEn && !prevXt) chk("R5 gap before crystal", lowRun >= GAP ? 1 : 0, 1);
      if (!rcSelEn && !xtalSelEn) lowRun++; else lowRun = 0;
      prevXt = xtalSelEn;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countTicks(output int n);
    n = 0;
    repeat (64) begin
      @(negedge clk);
      if (cpuTick) n++;
    end
  endtask

  task automatic doSleep();
    @(negedge clk); sleepReq = 1;
    @(negedge clk); sleepReq = 0;
    waitN(1);
  endtask

  task automatic doWake();
    @(negedge clk); wakeEvt = 1;
    @(negedge clk); wakeEvt = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  endtask

  // watchdog
  initial begin
    #200000;
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int nt;
    waitN(4);
    // R1: reset state
    chk("R1 reset rc", rcSelEn, 0);
    chk("R1 reset xtal", xtalSelEn, 0);
    chk("R9 reset sleep rc", slpRcEn, 1);
    chk("R11 reset status", status, 0);
    @(negedge clk); rstN = 1;
    waitN(4);
    chk("R1 no source before rcReady", rcSelEn | xtalSelEn, 0);
    rcReady = 1;
    waitN(3);
    chk("R1 rc after ready", rcSelEn, 1);

    // R2: automatic policy
    waitN(5);
    chk("R2 still rc without crystal", rcSelEn, 1);
    xtalReady = 1;
    waitN(GAP + 4);
    chk("R2 auto switch", xtalSelEn, 1);
    chk("R11 status crystal bit", status[0], 1);

    // R7 / R8: tick rates
    for (int k = 0; k <= 5; k++) begin
      @(negedge clk); divCode = 3'(k);
      waitN(4);
      countTicks(nt);
      chk($sformatf("R7 ticks code %0d", k), nt, 64 >> (5 - k));
    end
    @(negedge clk); divCode = 3'd2;
    waitN(4);
    @(negedge clk); divCode = 3'd7;
    waitN(4);
    countTicks(nt);
    chk("R8 code 7 ignored", nt, 8);
    @(negedge clk); divCode = 3'd6;
    waitN(4);
    countTicks(nt);
    chk("R8 code 6 ignored", nt, 8);
    @(negedge clk); divCode = 3'd5;

    // R6: sleep from crystal
    doSleep();
    chk("R6 asleep", asleep, 1);
    chk("R6 enables dropped", rcSelEn | xtalSelEn, 0);
    waitN(3);
    chk("R7 no ticks asleep", cpuTick, 0);

    // R3: manual policy with early switch command
    policy = 2'd1; xtalReady = 0; rcReady = 0;
    doWake();
    waitN(4);
    chk("R1 wake waits for rc", rcSelEn | xtalSelEn, 0);
    rcReady = 1;
    waitN(4);
    chk("R1 wake on rc", rcSelEn, 1);
    @(negedge clk); swSwitch = 1;
    @(negedge clk); swSwitch = 0;
    waitN(2);
    chk("R3 pending flag", status[1], 1);
    waitN(8);
    chk("R3 waits for crystal", rcSelEn, 1);
    xtalReady = 1;
    waitN(GAP + 4);
    chk("R3 switched when ready", xtalSelEn, 1);
    chk("R3 pending cleared", status[1], 0);

    // R6: pending cleared by sleep
    doSleep();
    xtalReady = 0;
    doWake();
    waitN(4);
    @(negedge clk); swSwitch = 1;
    @(negedge clk); swSwitch = 0;
    waitN(2);
    chk("R3 pending again", status[1], 1);
    doSleep();
    chk("R6 sleep clears pending", status[1], 0);

    // R4: hold policy
    policy = 2'd2; xtalReady = 1;
    doWake();
    waitN(4);
    @(negedge clk); swSwitch = 1;
    @(negedge clk); swSwitch = 0;
    waitN(30);
    chk("R4 hold stays rc", rcSelEn, 1);
    chk("R4 hold no crystal", xtalSelEn, 0);
    policy = 2'd3;
    waitN(10);
    chk("R4 code 3 holds", rcSelEn, 1);
    doSleep();
    chk("R6 sleep from hold", asleep, 1);

    // R9 / R10: sleep clock source
    @(negedge clk); slpSrcWr = 1; slpSrcSel = 2'd3;
    @(negedge clk); slpSrcWr = 0;
    waitN(2);
    chk("R10 code 3 ignored", slpRcEn, 1);
    @(negedge clk); slpSrcWr = 1; slpSrcSel = 2'd1;
    @(negedge clk); slpSrcWr = 0;
    chk("R9 break cycle", {slpExtEn, slpXtalEn, slpRcEn}, 0);
    @(negedge clk);
    chk("R9 crystal sleep clock", slpXtalEn, 1);
    chk("R11 locked status", status[4:2], 3'b101);
    @(negedge clk); slpSrcWr = 1; slpSrcSel = 2'd2;
    @(negedge clk); slpSrcWr = 0;
    waitN(2);
    chk("R10 locked write ignored", {slpExtEn, slpXtalEn, slpRcEn}, 2);

    // automatic wake into crystal once more
    policy = 2'd0;
    doWake();
    waitN(GAP + 8);
    chk("R2 auto after wake", xtalSelEn, 1);

    waitN(4);
    summary();
  end

endmodule